// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block holds the pending and in-service state of a local interrupt controller that has 256 vectors. Interrupt deliveries come in on a valid/ready stream. Each delivery carries a vector number and a trigger type. An accepted delivery sets the vector's request bit and records whether the vector is level or edge triggered. The block finds the highest pending vector and compares it with the highest in-service vector and with a task-priority threshold. From that it drives a single interrupt-pending line to the processor.

The processor takes an interrupt by pulsing an acknowledge request. One cycle later the block answers with the vector it granted, and that vector moves from pending to in service. Software ends a handler by writing the end-of-interrupt register. When the finished vector was level triggered, the block also sends a remote end-of-interrupt strobe carrying that vector. A 32-bit register port gives access to the task priority, the error status and a command register. The command register can inject vectors into this same controller. The three bitmaps can be read in 32-bit slices.

Top module: `irq_prio_tracker`

## Requirements
- R1: An accepted delivery of vector V (V >= 16) whose request bit is clear sets request bit V. It also sets trigger bit V when `dlv_level` is 1, and clears trigger bit V when `dlv_level` is 0.
- R2: A delivery of a vector whose request bit is already set is dropped. The request and trigger bitmaps do not change.
- R3: A delivery of a vector below 16 changes no bitmap. It sets bit 6 (illegal vector) of the internal error value.
- R4: `irq_pending` is 1 exactly when all three of these hold: some request bit is set; the highest request vector H is above the highest in-service vector, or no vector is in service; and H[7:4] is greater than the task priority's bits 7:4.
- R5: An acknowledge request is answered one cycle later on `ack_done`. If `irq_pending` was 1, then `ack_hit` is 1 and `ack_vector` is H, and request bit H is cleared while in-service bit H is set. Otherwise `ack_hit` is 0, `ack_vector` is 0 and no state changes.
- R6: A write to offset 0xB0, whatever its data, clears the highest set in-service bit. If that vector's trigger bit was set, `eoi_valid` pulses for one cycle on the next cycle with `eoi_vector` equal to that vector. If no in-service bit is set, the write has no effect.
- R7: Writes to the task priority at 0x80 keep only bits 7:0. Reads return those bits zero-extended.
- R8: A command write at 0x300 decodes vector [7:0], delivery mode [10:8], level flag [15] and shorthand [19:18]. Shorthand 1 injects the vector locally as a fixed-mode delivery. Shorthand 2 injects it locally unless the mode is 4 or 5. Shorthands 0 and 3 have no local effect. An injection follows R1 to R3.
- R9: Reading the command register at 0x300 returns the last written value with bit 12 forced to 0.
- R10: Any write to 0x280 copies the internal error value into the readable error register at 0x280 and clears the internal value. An error raised in the same cycle is kept.
- R11: Reads are combinational. In-service slice i is at 0x100+16*i, trigger slice i at 0x180+16*i and request slice i at 0x200+16*i, with bit j of slice i meaning vector 32*i+j. Any other address reads 0.
- R12: `dlv_ready` is 0 in any cycle that presents a write to 0x300 and is 1 otherwise. A delivery is accepted only when valid and ready are both 1. A held delivery must keep its vector and level stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery request valid |
| dlv_ready | output | 1 | Delivery can be accepted this cycle |
| dlv_vector | input | 8 | Delivered vector |
| dlv_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_pending | output | 1 | An interrupt should be taken |
| ack_req | input | 1 | Processor acknowledge request |
| ack_done | output | 1 | Acknowledge answered (one cycle after the request) |
| ack_hit | output | 1 | A vector was granted |
| ack_vector | output | 8 | Granted vector |
| eoi_valid | output | 1 | Remote end-of-interrupt strobe |
| eoi_vector | output | 8 | Vector of the remote end-of-interrupt |

## Verification
The bound assertions check these rules on every cycle: a pending line always has a request behind it; the acknowledge answers with a hit or a miss that matches the pending line; a granted vector ends up in service and not pending; a remote end-of-interrupt appears only after an end-of-interrupt write and leaves its vector out of service; the status bit of the command register reads as zero; low vectors raise the error flag; and the stream stalls during command writes. Other behaviour depends on the contents of the bitmaps, so only the bench's scenarios show it. This covers duplicate drops that leave the trigger bit alone, the class comparison against the task priority, shorthand and mode filtering, and the timing of the error-register latch.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 12;
  localparam int ERR_W  = 8;
  localparam int ERR_ILLEGAL = 6;

  localparam logic [ADDR_W-1:0] A_TPR = 12'h080;
  localparam logic [ADDR_W-1:0] A_EOI = 12'h0B0;
  localparam logic [ADDR_W-1:0] A_ISR = 12'h100;
  localparam logic [ADDR_W-1:0] A_TMR = 12'h180;
  localparam logic [ADDR_W-1:0] A_IRR = 12'h200;
  localparam logic [ADDR_W-1:0] A_ESR = 12'h280;
  localparam logic [ADDR_W-1:0] A_ICR = 12'h300;

  typedef enum logic [1:0] {
    SH_NONE     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL_INCL = 2'd2,
    SH_ALL_EXCL = 2'd3
  } shorthand_e;

  localparam logic [2:0] MODE_NMI  = 3'd4;
  localparam logic [2:0] MODE_INIT = 3'd5;
endpackage

// File: rtl/vic_hi_find.sv
module vic_hi_find #(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 32,
  localparam int WSEL_W = $clog2(N_WORDS),
  localparam int BSEL_W = $clog2(WORD_W)
) (
  input  logic [N_WORDS*WORD_W-1:0] bits,
  output logic                      found,
  output logic [WSEL_W+BSEL_W-1:0]  idx
);
  logic [N_WORDS-1:0] word_any;
  logic [WSEL_W-1:0]  wsel;
  logic [BSEL_W-1:0]  bsel;
  logic [WORD_W-1:0]  word;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign word_any[w] = |bits[w*WORD_W +: WORD_W];
  end

  // first level: highest non-empty word
  always_comb begin
    wsel = '0;
    for (int w = 0; w < N_WORDS; w++)
      if (word_any[w]) wsel = WSEL_W'(w);
  end

  assign word = bits[wsel*WORD_W +: WORD_W];

  // second level: highest bit inside the chosen word
  always_comb begin
    bsel = '0;
    for (int b = 0; b < WORD_W; b++)
      if (word[b]) bsel = BSEL_W'(b);
  end

  assign found = |word_any;
  assign idx   = {wsel, bsel};
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic               req_found,
  input  logic [VEC_W-1:0]   req_idx,
  input  logic               svc_found,
  input  logic [VEC_W-1:0]   svc_idx,
  input  logic [CLASS_W-1:0] tpr_class,
  output logic               take
);
  logic above_svc, above_tpr;

  assign above_svc = !svc_found || (req_idx > svc_idx);
  assign above_tpr = req_idx[VEC_W-1 -: CLASS_W] > tpr_class;
  assign take      = req_found && above_svc && above_tpr;
endmodule

// File: rtl/vic_read_mux.sv
module vic_read_mux
  import vic_pkg::*;
#(
  parameter int NVEC    = 256,
  parameter int SLICE_W = 32,
  parameter int VEC_W   = 8,
  localparam int NSLICE = NVEC / SLICE_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NVEC-1:0]    isr,
  input  logic [NVEC-1:0]    tmr,
  input  logic [NVEC-1:0]    irr,
  input  logic [VEC_W-1:0]   tpr,
  input  logic [ERR_W-1:0]   esr,
  input  logic [SLICE_W-1:0] icr,
  output logic [SLICE_W-1:0] rdata
);
  localparam int WA_W = ADDR_W - 4;

  logic [WA_W-1:0] wa;
  logic            aligned;

  assign wa      = addr[ADDR_W-1:4];
  assign aligned = (addr[3:0] == 4'h0);

  function automatic logic [SLICE_W-1:0] pick(input logic [NVEC-1:0] v,
                                              input logic [WA_W-1:0] off);
    pick = '0;
    for (int s = 0; s < NSLICE; s++)
      if (int'(off) == s) pick = v[s*SLICE_W +: SLICE_W];
  endfunction

  always_comb begin
    logic [WA_W-1:0] o_isr, o_tmr, o_irr;
    o_isr = wa - A_ISR[ADDR_W-1:4];
    o_tmr = wa - A_TMR[ADDR_W-1:4];
    o_irr = wa - A_IRR[ADDR_W-1:4];
    rdata = '0;
    if (aligned) begin
      if (addr == A_TPR)                                rdata = SLICE_W'(tpr);
      else if (addr == A_ESR)                           rdata = SLICE_W'(esr);
      else if (addr == A_ICR)                           rdata = icr;
      else if (wa >= A_ISR[ADDR_W-1:4] && int'(o_isr) < NSLICE) rdata = pick(isr, o_isr);
      else if (wa >= A_TMR[ADDR_W-1:4] && int'(o_tmr) < NSLICE) rdata = pick(tmr, o_tmr);
      else if (wa >= A_IRR[ADDR_W-1:4] && int'(o_irr) < NSLICE) rdata = pick(irr, o_irr);
    end
  end
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
  import vic_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int SLICE_W = 32,
  localparam int NVEC   = 1 << VEC_W,
  localparam int NSLICE = NVEC / SLICE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dlv_valid,
  output logic               dlv_ready,
  input  logic [VEC_W-1:0]   dlv_vector,
  input  logic               dlv_level,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [SLICE_W-1:0] reg_wdata,
  output logic [SLICE_W-1:0] reg_rdata,
  output logic               irq_pending,
  input  logic               ack_req,
  output logic               ack_done,
  output logic               ack_hit,
  output logic [VEC_W-1:0]   ack_vector,
  output logic               eoi_valid,
  output logic [VEC_W-1:0]   eoi_vector
);
  logic [NVEC-1:0]    irr_q, isr_q, tmr_q, irr_n, isr_n, tmr_n;
  logic [VEC_W-1:0]   tpr_q;
  logic [SLICE_W-1:0] icr_q;
  logic [ERR_W-1:0]   err_q, err_n, esr_q;

  logic             irr_found, isr_found, take;
  logic [VEC_W-1:0] irr_idx, isr_idx;

  vic_hi_find #(.N_WORDS(NSLICE), .WORD_W(SLICE_W)) u_find_irr (
    .bits(irr_q), .found(irr_found), .idx(irr_idx));
  vic_hi_find #(.N_WORDS(NSLICE), .WORD_W(SLICE_W)) u_find_isr (
    .bits(isr_q), .found(isr_found), .idx(isr_idx));

  vic_arbiter #(.VEC_W(VEC_W), .CLASS_W(4)) u_arb (
    .req_found(irr_found), .req_idx(irr_idx),
    .svc_found(isr_found), .svc_idx(isr_idx),
    .tpr_class(tpr_q[VEC_W-1 -: 4]), .take(take));

  vic_read_mux #(.NVEC(NVEC), .SLICE_W(SLICE_W), .VEC_W(VEC_W)) u_rd (
    .addr(reg_addr), .isr(isr_q), .tmr(tmr_q), .irr(irr_q),
    .tpr(tpr_q), .esr(esr_q), .icr(icr_q), .rdata(reg_rdata));

  // register write decode
  logic wr_tpr, wr_eoi, wr_esr, wr_icr;
  assign wr_tpr = reg_wr && reg_addr == A_TPR;
  assign wr_eoi = reg_wr && reg_addr == A_EOI;
  assign wr_esr = reg_wr && reg_addr == A_ESR;
  assign wr_icr = reg_wr && reg_addr == A_ICR;

  // command register: local injection decode
  shorthand_e icr_sh;
  logic [2:0] icr_mode;
  logic       icr_inj;
  assign icr_sh   = shorthand_e'(reg_wdata[19:18]);
  assign icr_mode = reg_wdata[10:8];
  assign icr_inj  = wr_icr && (icr_sh == SH_SELF ||
                    (icr_sh == SH_ALL_INCL && icr_mode != MODE_NMI && icr_mode != MODE_INIT));

  // one insertion port shared by stream and command register
  assign dlv_ready = !wr_icr;

  logic             in_valid, in_lvl, in_bad, in_new, grant;
  logic [VEC_W-1:0] in_vec;
  assign in_valid = icr_inj || (dlv_valid && dlv_ready);
  assign in_vec   = icr_inj ? reg_wdata[VEC_W-1:0] : dlv_vector;
  assign in_lvl   = icr_inj ? reg_wdata[15] : dlv_level;
  assign in_bad   = in_vec < VEC_W'(16);
  assign in_new   = in_valid && !in_bad && !irr_q[in_vec];
  assign grant    = ack_req && take;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (grant) begin
      irr_n[irr_idx] = 1'b0;
      isr_n[irr_idx] = 1'b1;
    end
    if (in_new) begin
      irr_n[in_vec] = 1'b1;
      tmr_n[in_vec] = in_lvl;
    end
    if (wr_eoi && isr_found) isr_n[isr_idx] = 1'b0;
    err_n = wr_esr ? '0 : err_q;
    if (in_valid && in_bad) err_n[ERR_ILLEGAL] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      icr_q      <= '0;
      err_q      <= '0;
      esr_q      <= '0;
      ack_done   <= 1'b0;
      ack_hit    <= 1'b0;
      ack_vector <= '0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      irr_q      <= irr_n;
      isr_q      <= isr_n;
      tmr_q      <= tmr_n;
      err_q      <= err_n;
      if (wr_esr) esr_q <= err_q;
      if (wr_tpr) tpr_q <= reg_wdata[VEC_W-1:0];
      if (wr_icr) icr_q <= reg_wdata & ~(SLICE_W'(1) << 12);
      ack_done   <= ack_req;
      ack_hit    <= grant;
      ack_vector <= grant ? irr_idx : '0;
      eoi_valid  <= wr_eoi && isr_found && tmr_q[isr_idx];
      eoi_vector <= (wr_eoi && isr_found && tmr_q[isr_idx]) ? isr_idx : '0;
    end
  end

  assign irq_pending = take;
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker
  import vic_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int NVEC  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dlv_valid,
  input logic              dlv_ready,
  input logic [VEC_W-1:0]  dlv_vector,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              icr_status_bit,
  input logic              irq_pending,
  input logic              ack_req,
  input logic              ack_done,
  input logic              ack_hit,
  input logic [VEC_W-1:0]  ack_vector,
  input logic              eoi_valid,
  input logic [VEC_W-1:0]  eoi_vector,
  input logic [NVEC-1:0]   irr,
  input logic [NVEC-1:0]   isr,
  input logic              err_illegal
);
  assert_pending_has_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (|irr));

  assert_ack_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !irq_pending) |=> (ack_done && !ack_hit));

  assert_ack_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && irq_pending) |=> (ack_done && ack_hit && isr[ack_vector] && !irr[ack_vector]));

  assert_eoi_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(reg_wr && reg_addr == A_EOI));

  assert_eoi_leaves_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !isr[eoi_vector]);

  assert_icr_status_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_ICR) |-> !icr_status_bit);

  assert_low_vector_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && dlv_vector < VEC_W'(16)) |=> err_illegal);

  assert_stall_on_command_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ICR) |-> !dlv_ready);
endmodule

bind irq_prio_tracker irq_prio_checker #(.VEC_W(VEC_W), .NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
  .dlv_vector(dlv_vector), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .icr_status_bit(reg_rdata[12]), .irq_pending(irq_pending), .ack_req(ack_req),
  .ack_done(ack_done), .ack_hit(ack_hit), .ack_vector(ack_vector),
  .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .irr(irr_q), .isr(isr_q),
  .err_illegal(err_q[vic_pkg::ERR_ILLEGAL]));

// File: tb/tb_irq_prio_tracker.sv
`timescale 1ns/1ps
module tb_irq_prio_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dlv_valid = 1'b0, dlv_level = 1'b0, reg_wr = 1'b0, ack_req = 1'b0;
  logic [7:0]  dlv_vector = '0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        dlv_ready, irq_pending, ack_done, ack_hit, eoi_valid;
  logic [31:0] reg_rdata;
  logic [7:0]  ack_vector, eoi_vector;

  always #5 clk = ~clk;

  irq_prio_tracker dut (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_vector(dlv_vector), .dlv_level(dlv_level), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pending(irq_pending), .ack_req(ack_req), .ack_done(ack_done),
    .ack_hit(ack_hit), .ack_vector(ack_vector), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [255:0] m_irr, m_isr, m_tmr;
  bit [7:0]   m_tpr, m_err, m_esr, m_ackv, m_eoivec;
  bit [31:0]  m_icr;
  bit         m_ackd, m_ackh, m_eoiv;

  function automatic int top_bit(input bit [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit m_pend();
    int hi = top_bit(m_irr);
    int hs = top_bit(m_isr);
    return (hi >= 0) && (hi > hs) && ((hi >> 4) > int'(m_tpr >> 4));
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == 12'h080) return {24'h0, m_tpr};
    if (a == 12'h280) return {24'h0, m_esr};
    if (a == 12'h300) return m_icr;
    if (a[3:0] == 4'h0) begin
      if (a >= 12'h100 && a < 12'h180) return m_isr[(a - 12'h100) * 2 +: 32];
      if (a >= 12'h180 && a < 12'h200) return m_tmr[(a - 12'h180) * 2 +: 32];
      if (a >= 12'h200 && a < 12'h280) return m_irr[(a - 12'h200) * 2 +: 32];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_err = '0; m_esr = '0;
      m_icr = '0; m_ackd = 0; m_ackh = 0; m_ackv = '0; m_eoiv = 0; m_eoivec = '0;
    end else begin
      bit [255:0] n_irr, n_isr, n_tmr;
      bit [7:0]   n_err, iv;
      bit         pend, inj, il, w_icr, w_eoi, w_esr;
      int         hi, hs;
      hi = top_bit(m_irr); hs = top_bit(m_isr); pend = m_pend();
      n_irr = m_irr; n_isr = m_isr; n_tmr = m_tmr;
      w_icr = reg_wr && reg_addr == 12'h300;
      w_eoi = reg_wr && reg_addr == 12'h0B0;
      w_esr = reg_wr && reg_addr == 12'h280;
      inj = 0; iv = '0; il = 0;
      if (w_icr) begin
        if (reg_wdata[19:18] == 2'd1 ||
            (reg_wdata[19:18] == 2'd2 && reg_wdata[10:8] != 3'd4 && reg_wdata[10:8] != 3'd5)) begin
          inj = 1; iv = reg_wdata[7:0]; il = reg_wdata[15];
        end
      end else if (dlv_valid) begin
        inj = 1; iv = dlv_vector; il = dlv_level;
      end
      n_err = w_esr ? 8'h0 : m_err;
      if (w_esr) m_esr = m_err;
      if (inj) begin
        if (iv < 16) n_err[6] = 1'b1;
        else if (!m_irr[iv]) begin n_irr[iv] = 1'b1; n_tmr[iv] = il; end
      end
      m_ackd = ack_req; m_ackh = ack_req && pend; m_ackv = m_ackh ? 8'(hi) : 8'h0;
      if (m_ackh) begin n_irr[hi] = 1'b0; n_isr[hi] = 1'b1; end
      m_eoiv = w_eoi && hs >= 0 && m_tmr[hs];
      m_eoivec = m_eoiv ? 8'(hs) : 8'h0;
      if (w_eoi && hs >= 0) n_isr[hs] = 1'b0;
      if (reg_wr && reg_addr == 12'h080) m_tpr = reg_wdata[7:0];
      if (w_icr) m_icr = reg_wdata & ~32'h1000;
      m_irr = n_irr; m_isr = n_isr; m_tmr = n_tmr; m_err = n_err;
    end
  end

  // per-cycle comparison, away from the clock edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      chk("R12 dlv_ready", {31'h0, dlv_ready}, {31'h0, !(reg_wr && reg_addr == 12'h300)});
      chk("R4 irq_pending", {31'h0, irq_pending}, {31'h0, m_pend()});
      chk("R11 reg_rdata", reg_rdata, m_read(reg_addr));
      chk("R5 ack", {22'h0, ack_done, ack_hit, ack_vector}, {22'h0, m_ackd, m_ackh, m_ackv});
      chk("R6 eoi", {23'h0, eoi_valid, eoi_vector}, {23'h0, m_eoiv, m_eoivec});
    end
  end

  // ---------------- stimulus ----------------
  task automatic deliver(input logic [7:0] v, input logic l);
    dlv_valid = 1; dlv_vector = v; dlv_level = l;
    @(negedge clk); dlv_valid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic ack();
    ack_req = 1;
    @(negedge clk); ack_req = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_chk("R11 reset irr", 12'h200, 32'h0);
    rd_chk("R7 reset tpr", 12'h080, 32'h0);

    deliver(8'h41, 0); deliver(8'h52, 1); deliver(8'h30, 1);
    deliver(8'h52, 0);  // duplicate
    rd_chk("R2 tmr kept", 12'h1A0, 32'h0004_0000);
    rd_chk("R1 irr slice2", 12'h220, 32'h0004_0002);
    rd_chk("R1 irr slice1", 12'h210, 32'h0001_0000);
    rd_chk("R1 tmr slice1", 12'h190, 32'h0001_0000);
    chk("R4 pending", {31'h0, irq_pending}, 32'h1);

    deliver(8'h05, 0);
    rd_chk("R3 irr slice0", 12'h200, 32'h0);
    rd_chk("R10 esr before", 12'h280, 32'h0);
    wr(12'h280, 32'h0);
    rd_chk("R10 esr latched", 12'h280, 32'h40);
    wr(12'h280, 32'h0);
    rd_chk("R10 esr cleared", 12'h280, 32'h0);

    wr(12'h080, 32'hFFFF_FF55);
    rd_chk("R7 tpr", 12'h080, 32'h55);
    chk("R4 masked by tpr", {31'h0, irq_pending}, 32'h0);
    wr(12'h080, 32'h40);
    chk("R4 unmasked", {31'h0, irq_pending}, 32'h1);

    ack(); #1;
    chk("R5 hit vector", {23'h0, ack_hit, ack_vector}, {23'h0, 1'b1, 8'h52});
    chk("R4 below service", {31'h0, irq_pending}, 32'h0);
    rd_chk("R5 isr", 12'h120, 32'h0004_0000);
    ack(); #1;
    chk("R5 miss", {23'h0, ack_hit, ack_vector}, 32'h0);
    rd_chk("R5 irr kept", 12'h220, 32'h0000_0002);

    wr(12'h0B0, 32'h0000_DEAD); #1;
    chk("R6 level eoi", {23'h0, eoi_valid, eoi_vector}, {23'h0, 1'b1, 8'h52});
    rd_chk("R6 isr cleared", 12'h120, 32'h0);
    wr(12'h080, 32'h20);
    ack(); #1;
    chk("R5 second hit", {23'h0, ack_hit, ack_vector}, {23'h0, 1'b1, 8'h41});
    wr(12'h0B0, 32'h0); #1;
    chk("R6 edge no pulse", {31'h0, eoi_valid}, 32'h0);
    wr(12'h0B0, 32'h1); #1;
    chk("R6 empty eoi", {31'h0, eoi_valid}, 32'h0);

    wr(12'h300, 32'h0004_1066);
    rd_chk("R9 status bit", 12'h300, 32'h0004_0066);
    rd_chk("R8 self", 12'h230, 32'h0000_0040);
    wr(12'h300, 32'h000C_0067);
    wr(12'h300, 32'h0008_0468);
    wr(12'h300, 32'h0000_006A);
    rd_chk("R8 no local", 12'h230, 32'h0000_0040);
    // command write with a delivery waiting on the stream
    dlv_valid = 1; dlv_vector = 8'h70; dlv_level = 0;
    reg_wr = 1; reg_addr = 12'h300; reg_wdata = 32'h0008_8069;
    @(negedge clk); reg_wr = 0; #1;
    chk("R12 ready after", {31'h0, dlv_ready}, 32'h1);
    @(negedge clk); dlv_valid = 0;
    rd_chk("R8 incl level", 12'h230, 32'h0001_0240);
    rd_chk("R8 tmr", 12'h1B0, 32'h0000_0200);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int pick;
      dlv_valid  = ($urandom % 3) == 0;
      dlv_vector = 8'($urandom);
      dlv_level  = 1'($urandom);
      ack_req    = ($urandom % 4) == 0;
      reg_wr     = ($urandom % 6) == 0;
      pick = $urandom % 10;
      case (pick)
        0: reg_addr = 12'h080;
        1, 2: reg_addr = 12'h0B0;
        3: reg_addr = 12'h280;
        4: reg_addr = 12'h300;
        5: reg_addr = 12'h100 + 12'(($urandom % 8) * 16);
        6: reg_addr = 12'h180 + 12'(($urandom % 8) * 16);
        7: reg_addr = 12'h200 + 12'(($urandom % 8) * 16);
        default: reg_addr = 12'($urandom);
      endcase
      reg_wdata = $urandom;
      if (pick == 0) reg_wdata[7:4] = 4'($urandom % 6);
      @(negedge clk);
    end
    dlv_valid = 0; ack_req = 0; reg_wr = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule